// File: doc/BRIEF.md
# Single-Channel Scatter-Gather DMA Engine

This block is one DMA channel. It copies a run of elements from a source address to a destination address in one direction only. Every element passes through a small internal FIFO. The source and destination can each be memory, with an incrementing address, or a peripheral data register, with a fixed address. The same engine therefore covers copies from memory to memory, from memory to a peripheral, from a peripheral to memory, and from one peripheral to another. All bus traffic goes out on one simplified 32-bit master port. That port uses a valid/ready handshake and has an error response.

Software sets the channel up on plain configuration inputs and then pulses a start input. The configuration gives:
- the source address and the destination address,
- the element count,
- the burst length,
- the element width,
- an increment flag for each side,
- byte order,
- whether the channel waits for peripheral requests,
- a pointer to the next descriptor.

The channel can be paced by a peripheral, which asks for either a single element or a burst. Otherwise it runs freely in bursts. When a segment ends and its next pointer is non-zero, the channel reads a four-word descriptor from memory, reloads its settings from it and carries on. This gives scatter-gather.

At the end of the whole chain the channel emits a one-cycle terminal-count pulse. A bus error stops the channel and emits a one-cycle error pulse instead.

Top module: `dma_chan`

## Requirements
- R1: After synchronous reset, `busy`, `m_valid`, `tc_pulse`, `err_pulse` and `p_ack` are low. The channel is idle. The stored byte order is little-endian.
- R2: Once `m_valid` is raised, it stays high until the cycle in which `m_ready` is high. Until then `m_addr`, `m_write`, `m_wdata` and `m_strb` hold their values.
- R3: With `cfg_wait_req`=0, the channel moves `cfg_count` elements in chunks. Each chunk is min(burst length, remaining count) elements. All reads of a chunk come before its writes. Elements are written in the order they were read. The FIFO never takes more than DEPTH entries.
- R4: Element width is encoded as 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. An incrementing address advances by 1, 2 or 4 bytes to match the width. A fixed address does not change. The source side and the destination side are controlled separately.
- R5: Byte lanes depend on byte order, with lo = the two low address bits.
  - 32-bit elements use all four lanes unchanged.
  - Little-endian: a byte sits in lane lo, and a halfword starts at lane 2*lo[1].
  - Big-endian: a byte sits in lane 3-lo, and a halfword starts at lane 2-2*lo[1].
  - Reads take the element from those lanes of `m_rdata`.
  - Writes put it there in `m_wdata` and set `m_strb` for exactly those lanes. All other lanes are zero.
- R6: With `cfg_wait_req`=1, the channel starts no bus transfer until a request is present.
  - `preq_single` moves one element.
  - `preq_burst` moves min(burst length, remaining count) elements.
  - `preq_burst` wins when both requests are high.
  - `p_ack` pulses for one cycle after the last write of the chunk is accepted.
- R7: The burst field holds the burst length minus one. Lengths run from 1 to DEPTH; with the default depth of 4, the field is 2 bits.
- R8: When a segment ends and the next pointer is non-zero, the channel reads words at next, next+4, next+8 and next+12. These are loaded as source, destination, next pointer and control, and the channel continues. The control word layout is:
  - bits [15:0]: count
  - bits [17:16]: burst field
  - bits [19:18]: width
  - bit 20: source increment
  - bit 21: destination increment
  - bit 22: wait for request
- R9: When the count reaches zero and the next pointer is zero, `tc_pulse` is high for exactly one cycle, and `busy` is low in that same cycle.
- R10: An error response to an accepted transfer stops the channel. In the next cycle `err_pulse` is high for one cycle, `busy` and `m_valid` are low, and no `tc_pulse` follows. No further bus transfer starts.
- R11: A segment whose count is zero transfers no elements.
- R12: A `cfg_start` pulse while `busy` is high has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start pulse; latches the configuration when idle |
| cfg_src | input | ADDR_W | First source address |
| cfg_dst | input | ADDR_W | First destination address |
| cfg_next | input | ADDR_W | Next descriptor pointer, zero ends the chain |
| cfg_count | input | CNT_W | Element count of the first segment |
| cfg_burst | input | log2(DEPTH) | Burst length minus one |
| cfg_width | input | 2 | Element width code |
| cfg_src_inc | input | 1 | Source address increments |
| cfg_dst_inc | input | 1 | Destination address increments |
| cfg_wait_req | input | 1 | Pace chunks by peripheral requests |
| cfg_big_endian | input | 1 | Big-endian lane order |
| preq_single | input | 1 | Peripheral asks for one element |
| preq_burst | input | 1 | Peripheral asks for a burst |
| p_ack | output | 1 | Requested chunk has completed |
| m_valid | output | 1 | Master transfer request |
| m_write | output | 1 | 1 = write, 0 = read |
| m_addr | output | ADDR_W | Transfer byte address |
| m_size | output | 2 | Transfer width code |
| m_wdata | output | 32 | Write data |
| m_strb | output | 4 | Write byte lanes |
| m_ready | input | 1 | Transfer accepted this cycle |
| m_rdata | input | 32 | Read data, valid with m_ready |
| m_err | input | 1 | Error response, valid with m_ready |
| busy | output | 1 | Channel enabled |
| tc_pulse | output | 1 | Terminal count of the chain |
| err_pulse | output | 1 | Transfer stopped on a bus error |

## Verification
The main function is exercised with these patterns, each of which separates a different class of fault:
- A word copy with a stalling bus and a burst that does not divide the count tells correct chunk splitting and hold-while-stalled apart from dropped or repeated elements.
- A byte copy into a fixed, unaligned destination separates the increment control of the two sides, and shows a little-endian lane error.
- A halfword copy in big-endian order from a fixed source shows a swapped lane rule.
- A paced run issues a single request and then both requests together. This separates single from burst handling and checks that the burst request wins.
- A two-segment linked chain, an error injected on the third read, and a zero-count start check descriptor reload, the stop on error, and the empty segment.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int WORD_W = 32;
  localparam int STRB_W = WORD_W / 8;

  // control word layout of a linked descriptor
  localparam int CW_CNT_LSB   = 0;
  localparam int CW_BURST_LSB = 16;
  localparam int CW_WIDTH_LSB = 18;
  localparam int CW_SINC_BIT  = 20;
  localparam int CW_DINC_BIT  = 21;
  localparam int CW_WREQ_BIT  = 22;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT,
    ST_RD,
    ST_WR,
    ST_LLI
  } chan_state_t;

  // bytes per element for a width code
  function automatic logic [2:0] elem_bytes(input logic [1:0] w);
    case (w)
      2'd0:    elem_bytes = 3'd1;
      2'd1:    elem_bytes = 3'd2;
      default: elem_bytes = 3'd4;
    endcase
  endfunction

  // lowest byte lane used by an element at address offset lo
  function automatic logic [1:0] lane_sel(input logic [1:0] w, input logic big,
                                          input logic [1:0] lo);
    case (w)
      2'd0:    lane_sel = big ? (2'd3 - lo) : lo;
      2'd1:    lane_sel = big ? (lo[1] ? 2'd0 : 2'd2) : (lo[1] ? 2'd2 : 2'd0);
      default: lane_sel = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   level;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdata = store[rp];
  assign empty = (level == '0);
  assign full  = (level == (AW+1)'(DEPTH));

endmodule

// File: rtl/dma_lane.sv
module dma_lane
  import dma_pkg::*;
(
  input  logic              big,
  input  logic [1:0]        width,
  input  logic [1:0]        rd_lo,
  input  logic [WORD_W-1:0] rdata,
  input  logic [1:0]        wr_lo,
  input  logic [WORD_W-1:0] elem,
  output logic [WORD_W-1:0] rd_elem,
  output logic [WORD_W-1:0] wr_word,
  output logic [STRB_W-1:0] wr_strb
);
  logic [1:0]        rl, wl;
  logic [WORD_W-1:0] mask;
  logic [STRB_W-1:0] smask;

  always_comb begin
    rl = lane_sel(width, big, rd_lo);
    wl = lane_sel(width, big, wr_lo);
    case (width)
      2'd0:    begin mask = 32'h0000_00FF; smask = 4'b0001; end
      2'd1:    begin mask = 32'h0000_FFFF; smask = 4'b0011; end
      default: begin mask = 32'hFFFF_FFFF; smask = 4'b1111; end
    endcase
    rd_elem = (rdata >> {rl, 3'b000}) & mask;
    wr_word = (elem & mask) << {wl, 3'b000};
    wr_strb = smask << wl;
  end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_start,
  input  logic [ADDR_W-1:0]        cfg_src,
  input  logic [ADDR_W-1:0]        cfg_dst,
  input  logic [ADDR_W-1:0]        cfg_next,
  input  logic [CNT_W-1:0]         cfg_count,
  input  logic [$clog2(DEPTH)-1:0] cfg_burst,
  input  logic [1:0]               cfg_width,
  input  logic                     cfg_src_inc,
  input  logic                     cfg_dst_inc,
  input  logic                     cfg_wait_req,
  input  logic                     cfg_big_endian,
  input  logic                     preq_single,
  input  logic                     preq_burst,
  output logic                     p_ack,
  output logic                     m_valid,
  output logic                     m_write,
  output logic [ADDR_W-1:0]        m_addr,
  output logic [1:0]               m_size,
  output logic [WORD_W-1:0]        m_wdata,
  output logic [STRB_W-1:0]        m_strb,
  input  logic                     m_ready,
  input  logic [WORD_W-1:0]        m_rdata,
  input  logic                     m_err,
  output logic                     busy,
  output logic                     tc_pulse,
  output logic                     err_pulse
);
  localparam int BW   = $clog2(DEPTH);
  localparam int LN_W = BW + 1;

  chan_state_t       state;
  logic [ADDR_W-1:0] src, dst, nxt;
  logic [ADDR_W-1:0] lli_src, lli_dst, lli_nxt;
  logic [CNT_W-1:0]  cnt;
  logic [BW-1:0]     burst_f;
  logic [1:0]        width_r;
  logic              s_inc, d_inc, wreq, big;
  logic [LN_W-1:0]   rd_left, wr_left;
  logic [1:0]        lli_idx;

  logic [LN_W-1:0]   burst_len, chunk_n;
  logic [ADDR_W-1:0] step_s, step_d;
  logic              accept;
  logic              fifo_push, fifo_pop, fifo_flush, fifo_empty, fifo_full;
  logic [WORD_W-1:0] fifo_rdata, rd_elem, wr_word;
  logic [STRB_W-1:0] wr_strb;

  always_comb begin
    burst_len  = LN_W'(burst_f) + LN_W'(1);
    chunk_n    = (cnt < CNT_W'(burst_len)) ? LN_W'(cnt) : burst_len;
    step_s     = s_inc ? ADDR_W'(elem_bytes(width_r)) : '0;
    step_d     = d_inc ? ADDR_W'(elem_bytes(width_r)) : '0;
    accept     = m_valid && m_ready;
    fifo_push  = (state == ST_RD) && accept && !m_err;
    fifo_pop   = (state == ST_WR) && accept && !m_err;
    fifo_flush = ((state == ST_IDLE) && cfg_start) || (accept && m_err);
  end

  dma_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (fifo_flush),
    .push  (fifo_push),
    .wdata (rd_elem),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  dma_lane u_lane (
    .big     (big),
    .width   (width_r),
    .rd_lo   (src[1:0]),
    .rdata   (m_rdata),
    .wr_lo   (dst[1:0]),
    .elem    (fifo_rdata),
    .rd_elem (rd_elem),
    .wr_word (wr_word),
    .wr_strb (wr_strb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      tc_pulse  <= 1'b0;
      err_pulse <= 1'b0;
      p_ack     <= 1'b0;
      m_valid   <= 1'b0;
      m_write   <= 1'b0;
      m_addr    <= '0;
      m_size    <= '0;
      m_wdata   <= '0;
      m_strb    <= '0;
      src       <= '0;
      dst       <= '0;
      nxt       <= '0;
      lli_src   <= '0;
      lli_dst   <= '0;
      lli_nxt   <= '0;
      cnt       <= '0;
      burst_f   <= '0;
      width_r   <= '0;
      s_inc     <= 1'b0;
      d_inc     <= 1'b0;
      wreq      <= 1'b0;
      big       <= 1'b0;
      rd_left   <= '0;
      wr_left   <= '0;
      lli_idx   <= '0;
    end else begin
      tc_pulse  <= 1'b0;
      err_pulse <= 1'b0;
      p_ack     <= 1'b0;
      if (accept && m_err) begin
        m_valid   <= 1'b0;
        busy      <= 1'b0;
        err_pulse <= 1'b1;
        state     <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (cfg_start) begin
              src     <= cfg_src;
              dst     <= cfg_dst;
              nxt     <= cfg_next;
              cnt     <= cfg_count;
              burst_f <= cfg_burst;
              width_r <= cfg_width;
              s_inc   <= cfg_src_inc;
              d_inc   <= cfg_dst_inc;
              wreq    <= cfg_wait_req;
              big     <= cfg_big_endian;
              busy    <= 1'b1;
              state   <= ST_ARM;
            end
          end
          ST_ARM: begin
            if (cnt == '0) begin
              if (nxt != '0) begin
                lli_idx <= '0;
                state   <= ST_LLI;
              end else begin
                tc_pulse <= 1'b1;
                busy     <= 1'b0;
                state    <= ST_IDLE;
              end
            end else if (wreq) begin
              state <= ST_WAIT;
            end else begin
              rd_left <= chunk_n;
              wr_left <= chunk_n;
              state   <= ST_RD;
            end
          end
          ST_WAIT: begin
            if (preq_burst) begin
              rd_left <= chunk_n;
              wr_left <= chunk_n;
              state   <= ST_RD;
            end else if (preq_single) begin
              rd_left <= LN_W'(1);
              wr_left <= LN_W'(1);
              state   <= ST_RD;
            end
          end
          ST_RD: begin
            if (!m_valid) begin
              m_valid <= 1'b1;
              m_write <= 1'b0;
              m_addr  <= src;
              m_size  <= width_r;
            end else if (m_ready) begin
              m_valid <= 1'b0;
              src     <= src + step_s;
              rd_left <= rd_left - LN_W'(1);
              if (rd_left == LN_W'(1)) state <= ST_WR;
            end
          end
          ST_WR: begin
            if (!m_valid) begin
              m_valid <= 1'b1;
              m_write <= 1'b1;
              m_addr  <= dst;
              m_size  <= width_r;
              m_wdata <= wr_word;
              m_strb  <= wr_strb;
            end else if (m_ready) begin
              m_valid <= 1'b0;
              dst     <= dst + step_d;
              cnt     <= cnt - CNT_W'(1);
              wr_left <= wr_left - LN_W'(1);
              if (wr_left == LN_W'(1)) begin
                p_ack <= wreq;
                state <= ST_ARM;
              end
            end
          end
          ST_LLI: begin
            if (!m_valid) begin
              m_valid <= 1'b1;
              m_write <= 1'b0;
              m_addr  <= nxt + ADDR_W'({lli_idx, 2'b00});
              m_size  <= 2'd2;
            end else if (m_ready) begin
              m_valid <= 1'b0;
              lli_idx <= lli_idx + 2'd1;
              case (lli_idx)
                2'd0: lli_src <= ADDR_W'(m_rdata);
                2'd1: lli_dst <= ADDR_W'(m_rdata);
                2'd2: lli_nxt <= ADDR_W'(m_rdata);
                default: begin
                  src     <= lli_src;
                  dst     <= lli_dst;
                  nxt     <= lli_nxt;
                  cnt     <= m_rdata[CW_CNT_LSB +: CNT_W];
                  burst_f <= m_rdata[CW_BURST_LSB +: BW];
                  width_r <= m_rdata[CW_WIDTH_LSB +: 2];
                  s_inc   <= m_rdata[CW_SINC_BIT];
                  d_inc   <= m_rdata[CW_DINC_BIT];
                  wreq    <= m_rdata[CW_WREQ_BIT];
                  state   <= ST_ARM;
                end
              endcase
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_err,
  input logic              m_write,
  input logic [ADDR_W-1:0] m_addr,
  input logic [31:0]       m_wdata,
  input logic [3:0]        m_strb,
  input logic              busy,
  input logic              tc_pulse,
  input logic              err_pulse,
  input logic              p_ack,
  input logic              fifo_push,
  input logic              fifo_pop,
  input logic              fifo_full,
  input logic              fifo_empty
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !m_valid && !tc_pulse && !err_pulse && !p_ack));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !m_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)
                               && $stable(m_wdata) && $stable(m_strb)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> !fifo_full);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
    p_ack |=> !p_ack);

  assert_tc_idle_R9: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> (!busy && !err_pulse));

  assert_tc_single_R9: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);

  assert_err_stop_R10: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_err) |=> (err_pulse && !busy && !m_valid));

  assert_err_single_R10: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);

endmodule

bind dma_chan dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_err      (m_err),
  .m_write    (m_write),
  .m_addr     (m_addr),
  .m_wdata    (m_wdata),
  .m_strb     (m_strb),
  .busy       (busy),
  .tc_pulse   (tc_pulse),
  .err_pulse  (err_pulse),
  .p_ack      (p_ack),
  .fifo_push  (fifo_push),
  .fifo_pop   (fifo_pop),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty)
);

// File: tb/dma_chan_tb.sv
`timescale 1ns/1ps
module dma_chan_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_start = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_next = '0;
  logic [15:0] cfg_count = '0;
  logic [1:0]  cfg_burst = '0;
  logic [1:0]  cfg_width = '0;
  logic        cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0, cfg_wait_req = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        preq_single = 1'b0, preq_burst = 1'b0;
  logic        p_ack, m_valid, m_write, busy, tc_pulse, err_pulse;
  logic [31:0] m_addr, m_wdata;
  logic [1:0]  m_size;
  logic [3:0]  m_strb;
  logic        m_ready = 1'b0, m_err = 1'b0;
  logic [31:0] m_rdata = '0;

  always #2.5 clk = ~clk;

  dma_chan u_dut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_next(cfg_next), .cfg_count(cfg_count), .cfg_burst(cfg_burst),
    .cfg_width(cfg_width), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_wait_req(cfg_wait_req), .cfg_big_endian(cfg_big_endian),
    .preq_single(preq_single), .preq_burst(preq_burst), .p_ack(p_ack),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_strb(m_strb), .m_ready(m_ready), .m_rdata(m_rdata),
    .m_err(m_err), .busy(busy), .tc_pulse(tc_pulse), .err_pulse(err_pulse)
  );

  int n_chk = 0, n_bad = 0;
  int tc_cnt = 0, err_cnt = 0, ack_cnt = 0, wr_cnt = 0, bus_cnt = 0;
  logic [31:0] mem [0:511];
  logic [67:0] exp_q [$];
  bit          stall_en = 1'b0, stall_ph = 1'b0;
  bit          err_en = 1'b0;
  logic [31:0] err_addr = '0;
  bit          pend = 1'b0;
  logic [31:0] pend_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // lane rule of R5
  function automatic int lane_of(input int w, input bit big, input int lo);
    if (w == 0) return big ? 3 - lo : lo;
    if (w == 1) return big ? (lo >= 2 ? 0 : 2) : (lo >= 2 ? 2 : 0);
    return 0;
  endfunction

  function automatic logic [31:0] wmask(input int w);
    return (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] smask(input int w);
    return (w == 0) ? 4'b0001 : (w == 1) ? 4'b0011 : 4'b1111;
  endfunction

  // driver side of the scoreboard: expected writes of one segment (R3, R4, R5)
  task automatic push_exp(input logic [31:0] src, input logic [31:0] dst, input int count,
                          input int w, input bit si, input bit di, input bit big);
    for (int k = 0; k < count; k++) begin
      logic [31:0] sa, da, word, el, data;
      logic [3:0]  st;
      int          sl, dl, step;
      step = (w == 0) ? 1 : (w == 1) ? 2 : 4;
      sa   = src + (si ? 32'(k * step) : 32'd0);
      da   = dst + (di ? 32'(k * step) : 32'd0);
      word = mem[sa[10:2]];
      sl   = lane_of(w, big, int'(sa[1:0]));
      dl   = lane_of(w, big, int'(da[1:0]));
      el   = (word >> (8 * sl)) & wmask(w);
      data = el << (8 * dl);
      st   = smask(w) << dl;
      exp_q.push_back({da, data, st});
    end
  endtask

  // bus model and monitor side of the scoreboard
  always @(negedge clk) begin
    m_ready = 1'b0;
    m_err   = 1'b0;
    if (!rst) begin
      if (tc_pulse)  tc_cnt++;
      if (err_pulse) err_cnt++;
      if (p_ack)     ack_cnt++;
      if (pend) chk(m_valid && m_addr == pend_addr, "R2", "request held while stalled",
                    {35'd0, m_valid, m_addr}, {35'd0, 1'b1, pend_addr});
      pend = 1'b0;
      if (m_valid) begin
        stall_ph = !stall_ph;
        if (!stall_en || stall_ph) begin
          m_ready = 1'b1;
          bus_cnt++;
          if (err_en && m_addr == err_addr) begin
            m_err = 1'b1;
          end else if (!m_write) begin
            m_rdata = mem[m_addr[10:2]];
          end else begin
            for (int b = 0; b < 4; b++)
              if (m_strb[b]) mem[m_addr[10:2]][8*b +: 8] = m_wdata[8*b +: 8];
            wr_cnt++;
            if (exp_q.size() == 0) begin
              chk(1'b0, "R3", "unexpected write", {m_addr, m_wdata, m_strb}, '0);
            end else begin
              logic [67:0] e;
              e = exp_q.pop_front();
              chk({m_addr, m_wdata, m_strb} == e, "R5", "write addr/data/strb",
                  {m_addr, m_wdata, m_strb}, e);
            end
          end
        end else begin
          pend      = 1'b1;
          pend_addr = m_addr;
        end
      end
    end
  end

  task automatic start(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] nxt,
                       input int count, input int bf, input int w, input bit si, input bit di,
                       input bit wq, input bit big);
    @(posedge clk); #1;
    cfg_src = src; cfg_dst = dst; cfg_next = nxt; cfg_count = 16'(count);
    cfg_burst = 2'(bf); cfg_width = 2'(w); cfg_src_inc = si; cfg_dst_inc = di;
    cfg_wait_req = wq; cfg_big_endian = big; cfg_start = 1'b1;
    @(posedge clk); #1;
    cfg_start = 1'b0;
  endtask

  task automatic wait_end();
    int t0 = tc_cnt;
    int e0 = err_cnt;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (tc_cnt != t0 || err_cnt != e0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_ack();
    int a0 = ack_cnt;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (ack_cnt != a0) break;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog: actual no completion expected completion");
    summary();
  end

  initial begin
    int t0, e0, w0, b0;
    for (int i = 0; i < 512; i++)
      mem[i] = {8'(i) ^ 8'h5A, 8'(i) + 8'h11, 8'(i) ^ 8'hC3, 8'(i)};
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk({busy, m_valid, tc_pulse, err_pulse, p_ack} == 5'b0, "R1", "reset outputs",
        68'({busy, m_valid, tc_pulse, err_pulse, p_ack}), 68'd0);

    // word copy, stalling bus, burst 4 over count 6; restart pulse while busy (R3, R7, R12)
    stall_en = 1'b1;
    t0 = tc_cnt; w0 = wr_cnt;
    push_exp(32'h100, 32'h400, 6, 2, 1, 1, 0);
    start(32'h100, 32'h400, 32'h0, 6, 3, 2, 1, 1, 0, 0);
    repeat (8) @(posedge clk);
    #1 cfg_dst = 32'h700; cfg_start = 1'b1;
    @(posedge clk); #1 cfg_start = 1'b0;
    wait_end();
    stall_en = 1'b0;
    chk(tc_cnt == t0 + 1, "R9", "one tc after word copy", 68'(tc_cnt - t0), 68'd1);
    chk(wr_cnt - w0 == 6, "R12", "writes unaffected by restart", 68'(wr_cnt - w0), 68'd6);
    chk(exp_q.size() == 0, "R3", "all word elements written", 68'(exp_q.size()), 68'd0);
    chk(!busy, "R9", "idle after tc", 68'(busy), 68'd0);

    // bytes, source increments, destination fixed and unaligned (R4, R5)
    w0 = wr_cnt;
    push_exp(32'h100, 32'h603, 5, 0, 1, 0, 0);
    start(32'h100, 32'h603, 32'h0, 5, 1, 0, 1, 0, 0, 0);
    wait_end();
    chk(wr_cnt - w0 == 5 && exp_q.size() == 0, "R4", "byte copy to fixed dst",
        68'(wr_cnt - w0), 68'd5);

    // big-endian halfwords from a fixed source, burst length 1 (R5, R7)
    w0 = wr_cnt;
    push_exp(32'h182, 32'h640, 3, 1, 0, 1, 1);
    start(32'h182, 32'h640, 32'h0, 3, 0, 1, 0, 1, 0, 1);
    wait_end();
    chk(wr_cnt - w0 == 3 && exp_q.size() == 0, "R5", "big-endian halfword copy",
        68'(wr_cnt - w0), 68'd3);

    // peripheral paced: no request, single, then both requests (R6)
    t0 = tc_cnt;
    push_exp(32'h40, 32'h680, 3, 2, 1, 1, 0);
    start(32'h40, 32'h680, 32'h0, 3, 3, 2, 1, 1, 1, 0);
    b0 = bus_cnt;
    repeat (20) @(negedge clk);
    chk(bus_cnt == b0 && busy, "R6", "no transfer without request",
        68'(bus_cnt - b0), 68'd0);
    w0 = wr_cnt;
    preq_single = 1'b1;
    wait_ack();
    preq_single = 1'b0;
    chk(wr_cnt - w0 == 1, "R6", "single request moves one", 68'(wr_cnt - w0), 68'd1);
    w0 = wr_cnt;
    preq_single = 1'b1; preq_burst = 1'b1;
    wait_ack();
    preq_single = 1'b0; preq_burst = 1'b0;
    chk(wr_cnt - w0 == 2, "R6", "burst wins, clipped to remaining", 68'(wr_cnt - w0), 68'd2);
    wait_end();
    chk(tc_cnt == t0 + 1 && exp_q.size() == 0, "R9", "tc after paced run",
        68'(tc_cnt - t0), 68'd1);

    // two-segment linked chain (R8)
    mem[32'h300 >> 2] = 32'h141;
    mem[32'h304 >> 2] = 32'h482;
    mem[32'h308 >> 2] = 32'h0;
    mem[32'h30C >> 2] = 32'd3 | (32'd1 << 16) | (32'd0 << 18) | (32'd1 << 20) | (32'd1 << 21);
    t0 = tc_cnt; w0 = wr_cnt;
    push_exp(32'h100, 32'h4C0, 2, 2, 1, 1, 0);
    push_exp(32'h141, 32'h482, 3, 0, 1, 1, 0);
    start(32'h100, 32'h4C0, 32'h300, 2, 3, 2, 1, 1, 0, 0);
    wait_end();
    repeat (10) @(negedge clk);
    chk(tc_cnt == t0 + 1, "R8", "single tc for whole chain", 68'(tc_cnt - t0), 68'd1);
    chk(wr_cnt - w0 == 5 && exp_q.size() == 0, "R8", "both segments written",
        68'(wr_cnt - w0), 68'd5);

    // error on third read (R10)
    t0 = tc_cnt; e0 = err_cnt; w0 = wr_cnt;
    err_en = 1'b1; err_addr = 32'h108;
    start(32'h100, 32'h780, 32'h0, 4, 3, 2, 1, 1, 0, 0);
    wait_end();
    b0 = bus_cnt;
    repeat (10) @(negedge clk);
    err_en = 1'b0;
    chk(err_cnt == e0 + 1, "R10", "error pulse", 68'(err_cnt - e0), 68'd1);
    chk(tc_cnt == t0 && wr_cnt == w0, "R10", "no tc and no writes after error",
        68'({tc_cnt - t0, wr_cnt - w0}), 68'd0);
    chk(!busy && bus_cnt == b0, "R10", "channel stopped", 68'({busy, bus_cnt - b0}), 68'd0);

    // zero-count segment (R11)
    t0 = tc_cnt; b0 = bus_cnt;
    start(32'h100, 32'h7C0, 32'h0, 0, 3, 2, 1, 1, 0, 0);
    wait_end();
    chk(tc_cnt == t0 + 1 && bus_cnt == b0, "R11", "empty segment, no transfers",
        68'({tc_cnt - t0, bus_cnt - b0}), 68'({32'd1, 32'd0}));

    summary();
  end

endmodule